// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps, for each cache block tracked at a home node, a directory entry that names its sharers with a few node pointers instead of one presence bit per node. Each entry has `PTRS` pointer slots of `log2(NODES)` bits, a valid bit per slot, an overflow bit and a round-robin victim index. Commands name a block, a node and an operation: add a sharer, remove a sharer, or write (the node takes the block for writing, and every other holder must be invalidated). The block answers each command with a one-cycle pulse that carries a `NODES`-bit target mask, where bit k stands for node k, presented all at once.

When a new sharer finds every slot in use, the build-time policy decides what happens. Broadcast sets the overflow bit, and the next write targets every node. No-broadcast evicts one recorded sharer, reports it in the mask and reuses its slot. Coarse vector reuses the pointer bits as a vector of `CV_BITS` group bits, where group g covers nodes g*GRP to g*GRP+GRP-1 with GRP = NODES/CV_BITS. Message transport and acknowledgement counting belong to the surrounding logic.

A two-state controller runs each command. In `ST_IDLE`, `cmd_ready` is high and a valid command is latched, which is the transition IDLE→APPLY. In `ST_APPLY`, the entry is read, updated and written back, and the result is registered, which is the transition APPLY→IDLE, taken always. Within an entry there are two representations: pointer mode (overflow clear) and overflowed mode (overflow set).

Top module: `sharer_ptr_dir`

## Requirements
- R1: `cmd_ready` is high exactly in `ST_IDLE`. A command with `cmd_valid` high while ready is accepted on that clock edge, `cmd_ready` is low for the next cycle, and the result appears on `inv_valid`/`inv_mask` during the cycle that follows, as a single-cycle pulse.
- R2: After reset every entry is empty (all slots invalid, overflow clear, victim index 0), `cmd_ready` is high and `inv_valid` is low. A write to any block then returns an empty mask.
- R3: Op codes are 0 none, 1 add, 2 remove, 3 write. In pointer mode, a write targets exactly the recorded sharers. The writing node is never set in any output mask.
- R4: Adding a node that is already recorded leaves the entry unchanged. A new node takes the lowest-index free slot.
- R5: In pointer mode, remove clears the slot holding that node.
- R6: Broadcast policy (`POLICY`=POL_BCAST): an add that finds all slots full sets overflow. A write to an overflowed entry targets all nodes except the writer.
- R7: No-broadcast policy: the sharer count never exceeds `PTRS`. An add that finds all slots full emits a one-hot mask naming the node in the slot given by the victim index, writes the newcomer there, and advances the index modulo `PTRS`.
- R8: Coarse policy: an add that finds all slots full sets overflow and forms the group vector from the groups of all recorded sharers plus the newcomer's group (group = node / GRP). Later adds set their group bit. A write targets every node in every set group, except the writer.
- R9: While overflowed, remove has no effect.
- R10: After a write the entry holds only the writer in slot 0, with overflow clear and victim index 0.
- R11: `inv_valid` is high exactly when the result mask is non-zero. Otherwise `inv_mask` is all zero.
- R12: Commands change only the entry of the addressed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command may be taken |
| cmd_op | input | 2 | 0 none, 1 add, 2 remove, 3 write |
| cmd_blk | input | log2(BLOCKS) | Block address selecting the entry |
| cmd_node | input | log2(NODES) | Node the command refers to |
| inv_valid | output | 1 | Invalidation targets present this cycle |
| inv_mask | output | NODES | Bit k set: node k must be invalidated |

## Verification
A corrupt pointer, valid bit, overflow bit or group vector stays hidden at the ports until a write to that block reads the entry. Under no-broadcast, an eviction also reads it. The fault then shows as a missing or extra bit in the pulse two cycles after that command is accepted, which may be many commands after the fault occurred. A wrong victim index shows only on the next full-entry add. The bench therefore ends many sequences with a write and compares every pulse against a model of all three policies, run on three instances in parallel.

// File: rtl/dirptr_pkg.sv
package dirptr_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_DEL  = 2'd2,
        OP_WR   = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        POL_BCAST   = 2'd0,
        POL_NOBCAST = 2'd1,
        POL_COARSE  = 2'd2
    } ovf_pol_e;
endpackage

// File: rtl/coarse_expand.sv
module coarse_expand #(
    parameter int NODES   = 16,
    parameter int CV_BITS = 8
) (
    input  logic [CV_BITS-1:0] grp_vec,
    output logic [NODES-1:0]   node_vec
);
    localparam int GRP = NODES / CV_BITS;

    for (genvar g = 0; g < NODES; g++) begin : g_node
        assign node_vec[g] = grp_vec[g / GRP];
    end
endmodule

// File: rtl/dir_entry_next.sv
module dir_entry_next
    import dirptr_pkg::*;
#(
    parameter int       NODES   = 16,
    parameter int       PTRS    = 2,
    parameter int       CV_BITS = 8,
    parameter ovf_pol_e POLICY  = POL_BCAST,
    localparam int IDW = $clog2(NODES),
    localparam int SLW = PTRS * IDW,
    localparam int RRW = (PTRS > 1) ? $clog2(PTRS) : 1
) (
    input  dir_op_e          op,
    input  logic [IDW-1:0]   node,
    input  logic [SLW-1:0]   cur_slots,
    input  logic [PTRS-1:0]  cur_vld,
    input  logic             cur_ovf,
    input  logic [RRW-1:0]   cur_rr,
    output logic [SLW-1:0]   nxt_slots,
    output logic [PTRS-1:0]  nxt_vld,
    output logic             nxt_ovf,
    output logic [RRW-1:0]   nxt_rr,
    output logic [NODES-1:0] mask
);
    localparam int GRP = NODES / CV_BITS;

    function automatic logic [CV_BITS-1:0] grp_bit(input logic [IDW-1:0] n);
        return CV_BITS'(1) << (n / IDW'(GRP));
    endfunction

    logic               hit, free;
    logic [RRW-1:0]     hit_idx, free_idx;
    logic [NODES-1:0]   ptr_mask, cv_nodes, self_bit;
    logic [CV_BITS-1:0] ptr_groups;
    logic [IDW-1:0]     victim;

    // Slot search: lowest index wins for both hit and free slot
    always_comb begin
        hit = 1'b0; hit_idx = '0; free = 1'b0; free_idx = '0;
        ptr_mask = '0; ptr_groups = '0;
        for (int s = PTRS - 1; s >= 0; s--) begin
            if (cur_vld[s] && cur_slots[s*IDW +: IDW] == node) begin
                hit = 1'b1; hit_idx = RRW'(s);
            end
            if (!cur_vld[s]) begin
                free = 1'b1; free_idx = RRW'(s);
            end
            if (cur_vld[s]) begin
                ptr_mask   = ptr_mask | (NODES'(1) << cur_slots[s*IDW +: IDW]);
                ptr_groups = ptr_groups | grp_bit(cur_slots[s*IDW +: IDW]);
            end
        end
    end

    coarse_expand #(.NODES(NODES), .CV_BITS(CV_BITS)) u_expand (
        .grp_vec  (cur_slots[CV_BITS-1:0]),
        .node_vec (cv_nodes)
    );

    assign self_bit = NODES'(1) << node;
    assign victim   = cur_slots[int'(cur_rr)*IDW +: IDW];

    always_comb begin
        nxt_slots = cur_slots;
        nxt_vld   = cur_vld;
        nxt_ovf   = cur_ovf;
        nxt_rr    = cur_rr;
        mask      = '0;
        unique case (op)
            OP_ADD: begin
                if (cur_ovf) begin
                    if (POLICY == POL_COARSE)
                        nxt_slots = cur_slots | SLW'(grp_bit(node));
                end else if (hit) begin
                    nxt_slots = cur_slots;
                end else if (free) begin
                    nxt_slots[int'(free_idx)*IDW +: IDW] = node;
                    nxt_vld[free_idx] = 1'b1;
                end else if (POLICY == POL_BCAST) begin
                    nxt_ovf = 1'b1;
                end else if (POLICY == POL_NOBCAST) begin
                    mask = NODES'(1) << victim;
                    nxt_slots[int'(cur_rr)*IDW +: IDW] = node;
                    nxt_rr = (int'(cur_rr) == PTRS - 1) ? '0 : cur_rr + RRW'(1);
                end else begin
                    nxt_ovf   = 1'b1;
                    nxt_slots = SLW'(ptr_groups | grp_bit(node));
                end
            end
            OP_DEL: begin
                if (!cur_ovf && hit) nxt_vld[hit_idx] = 1'b0;
            end
            OP_WR: begin
                if (cur_ovf) mask = (POLICY == POL_COARSE) ? cv_nodes : '1;
                else         mask = ptr_mask;
                mask      = mask & ~self_bit;
                nxt_slots = SLW'(node);
                nxt_vld   = PTRS'(1);
                nxt_ovf   = 1'b0;
                nxt_rr    = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sharer_ptr_dir.sv
module sharer_ptr_dir
    import dirptr_pkg::*;
#(
    parameter int       NODES   = 16,
    parameter int       PTRS    = 2,
    parameter int       BLOCKS  = 8,
    parameter int       CV_BITS = 8,
    parameter ovf_pol_e POLICY  = POL_BCAST,
    localparam int IDW = $clog2(NODES),
    localparam int BW  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [BW-1:0]    cmd_blk,
    input  logic [IDW-1:0]   cmd_node,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_mask
);
    localparam int SLW = PTRS * IDW;
    localparam int RRW = (PTRS > 1) ? $clog2(PTRS) : 1;

    typedef enum logic {ST_IDLE, ST_APPLY} fsm_e;
    fsm_e state, state_nx;

    logic [SLW-1:0]  ent_slots [BLOCKS];
    logic [PTRS-1:0] ent_vld   [BLOCKS];
    logic            ent_ovf   [BLOCKS];
    logic [RRW-1:0]  ent_rr    [BLOCKS];

    dir_op_e        lat_op;
    logic [BW-1:0]  lat_blk;
    logic [IDW-1:0] lat_node;

    logic [SLW-1:0]   n_slots;
    logic [PTRS-1:0]  n_vld;
    logic             n_ovf;
    logic [RRW-1:0]   n_rr;
    logic [NODES-1:0] n_mask;

    dir_entry_next #(
        .NODES(NODES), .PTRS(PTRS), .CV_BITS(CV_BITS), .POLICY(POLICY)
    ) u_next (
        .op        (lat_op),
        .node      (lat_node),
        .cur_slots (ent_slots[lat_blk]),
        .cur_vld   (ent_vld[lat_blk]),
        .cur_ovf   (ent_ovf[lat_blk]),
        .cur_rr    (ent_rr[lat_blk]),
        .nxt_slots (n_slots),
        .nxt_vld   (n_vld),
        .nxt_ovf   (n_ovf),
        .nxt_rr    (n_rr),
        .mask      (n_mask)
    );

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = cmd_valid ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign cmd_ready = (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_op    <= OP_NONE;
            lat_blk   <= '0;
            lat_node  <= '0;
            inv_valid <= 1'b0;
            inv_mask  <= '0;
            for (int b = 0; b < BLOCKS; b++) begin
                ent_slots[b] <= '0;
                ent_vld[b]   <= '0;
                ent_ovf[b]   <= 1'b0;
                ent_rr[b]    <= '0;
            end
        end else begin
            inv_valid <= 1'b0;
            inv_mask  <= '0;
            if (state == ST_IDLE && cmd_valid) begin
                lat_op   <= dir_op_e'(cmd_op);
                lat_blk  <= cmd_blk;
                lat_node <= cmd_node;
            end
            if (state == ST_APPLY) begin
                ent_slots[lat_blk] <= n_slots;
                ent_vld[lat_blk]   <= n_vld;
                ent_ovf[lat_blk]   <= n_ovf;
                ent_rr[lat_blk]    <= n_rr;
                inv_valid          <= |n_mask;
                inv_mask           <= n_mask;
            end
        end
    end

    // R1: accepted command blocks the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R1: result is a single-cycle pulse
    p_pulse_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);
    // R11: mask quiet outside a pulse
    p_quiet_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |-> (inv_mask == '0));
    // R3: the commanding node is never a target
    p_skip_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !inv_mask[lat_node]);
    // R7: an eviction names exactly one node
    p_single_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_NOBCAST && inv_valid && lat_op == OP_ADD) |-> ($countones(inv_mask) == 1));
    // R7: no-broadcast entries never overflow
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_NOBCAST && state == ST_APPLY) |-> !ent_ovf[lat_blk]);
endmodule

// File: tb/sim_sharer_ptr_dir.sv
module sim_sharer_ptr_dir;
    import dirptr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NODES = 16;
    localparam int PTRS = 2;
    localparam int BLOCKS = 4;
    localparam int CVB = 8;
    localparam int GRP = NODES / CVB;
    localparam int IDW = $clog2(NODES);
    localparam int BW = $clog2(BLOCKS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [BW-1:0] cmd_blk = '0;
    logic [IDW-1:0] cmd_node = '0;
    logic rdy_o [3];
    logic vld_o [3];
    logic [NODES-1:0] msk_o [3];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sharer_ptr_dir #(.NODES(NODES), .PTRS(PTRS), .BLOCKS(BLOCKS), .CV_BITS(CVB), .POLICY(POL_BCAST)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_o[0]), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_node(cmd_node), .inv_valid(vld_o[0]), .inv_mask(msk_o[0]));
    sharer_ptr_dir #(.NODES(NODES), .PTRS(PTRS), .BLOCKS(BLOCKS), .CV_BITS(CVB), .POLICY(POL_NOBCAST)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_o[1]), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_node(cmd_node), .inv_valid(vld_o[1]), .inv_mask(msk_o[1]));
    sharer_ptr_dir #(.NODES(NODES), .PTRS(PTRS), .BLOCKS(BLOCKS), .CV_BITS(CVB), .POLICY(POL_COARSE)) u2 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_o[2]), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_node(cmd_node), .inv_valid(vld_o[2]), .inv_mask(msk_o[2]));

    // Reference model of the entries: index 0 broadcast, 1 no-broadcast, 2 coarse
    int m_ptr [3][BLOCKS][PTRS];
    bit m_vld [3][BLOCKS][PTRS];
    bit m_ovf [3][BLOCKS];
    bit [CVB-1:0] m_cv [3][BLOCKS];
    int m_rr [3][BLOCKS];

    function automatic logic [NODES-1:0] model_step(int p, int op, int b, int n, output string tag);
        logic [NODES-1:0] m = '0;
        bit hit = 1'b0;
        int fr = -1;
        tag = "R3";
        if (op == 1) begin
            if (m_ovf[p][b]) begin
                tag = (p == 2) ? "R8" : "R6";
                if (p == 2) m_cv[p][b][n / GRP] = 1'b1;
            end else begin
                for (int s = 0; s < PTRS; s++) if (m_vld[p][b][s] && m_ptr[p][b][s] == n) hit = 1'b1;
                for (int s = PTRS - 1; s >= 0; s--) if (!m_vld[p][b][s]) fr = s;
                if (hit) tag = "R4";
                else if (fr >= 0) begin
                    m_ptr[p][b][fr] = n; m_vld[p][b][fr] = 1'b1;
                end else if (p == 0) begin
                    m_ovf[p][b] = 1'b1; tag = "R6";
                end else if (p == 1) begin
                    m[m_ptr[p][b][m_rr[p][b]]] = 1'b1;
                    m_ptr[p][b][m_rr[p][b]] = n;
                    m_rr[p][b] = (m_rr[p][b] + 1) % PTRS;
                    tag = "R7";
                end else begin
                    m_cv[p][b] = '0;
                    for (int s = 0; s < PTRS; s++) m_cv[p][b][m_ptr[p][b][s] / GRP] = 1'b1;
                    m_cv[p][b][n / GRP] = 1'b1;
                    m_ovf[p][b] = 1'b1; tag = "R8";
                end
            end
        end else if (op == 2) begin
            if (m_ovf[p][b]) tag = "R9";
            else begin
                tag = "R5";
                for (int s = 0; s < PTRS; s++) if (m_vld[p][b][s] && m_ptr[p][b][s] == n) m_vld[p][b][s] = 1'b0;
            end
        end else if (op == 3) begin
            tag = "R10";
            if (m_ovf[p][b] && p == 0) begin m = '1; tag = "R6"; end
            else if (m_ovf[p][b]) begin
                for (int k = 0; k < NODES; k++) m[k] = m_cv[p][b][k / GRP];
                tag = "R8";
            end else
                for (int s = 0; s < PTRS; s++) if (m_vld[p][b][s]) m[m_ptr[p][b][s]] = 1'b1;
            m[n] = 1'b0;
            for (int s = 0; s < PTRS; s++) m_vld[p][b][s] = 1'b0;
            m_ptr[p][b][0] = n; m_vld[p][b][0] = 1'b1;
            m_ovf[p][b] = 1'b0; m_rr[p][b] = 0;
        end
        return m;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [NODES-1:0] act, logic [NODES-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called at a negedge with the bench idle; returns at a negedge
    task automatic run_cmd(int op, int b, int n, string tag_in);
        logic [NODES-1:0] exp [3];
        string t [3];
        for (int p = 0; p < 3; p++) begin
            exp[p] = model_step(p, op, b, n, t[p]);
            if (tag_in != "") t[p] = tag_in;
        end
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_blk = BW'(b); cmd_node = IDW'(n);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        for (int p = 0; p < 3; p++)
            chk(rdy_o[p] == 1'b0 && vld_o[p] == 1'b0, "R1", $sformatf("u%0d busy after accept", p),
                NODES'({rdy_o[p], vld_o[p]}), '0);
        @(posedge clk); @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            chk(msk_o[p] == exp[p], t[p], $sformatf("u%0d mask op%0d blk%0d node%0d", p, op, b, n), msk_o[p], exp[p]);
            chk(vld_o[p] == (exp[p] != '0) && rdy_o[p], "R11", $sformatf("u%0d valid", p),
                NODES'(vld_o[p]), NODES'(exp[p] != '0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < BLOCKS; b++) begin
                for (int s = 0; s < PTRS; s++) begin m_ptr[p][b][s] = 0; m_vld[p][b][s] = 1'b0; end
                m_ovf[p][b] = 1'b0; m_cv[p][b] = '0; m_rr[p][b] = 0;
            end
        sd = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 3; p++)
            chk(rdy_o[p] && !vld_o[p] && msk_o[p] == '0, "R2", $sformatf("u%0d reset outputs", p),
                NODES'({rdy_o[p], vld_o[p]}), NODES'(2));
        // R2: empty entries after reset
        for (int b = 0; b < BLOCKS; b++) run_cmd(3, b, 0, "R2");
        // R3: exact pointers
        run_cmd(3, 1, 7, ""); run_cmd(1, 1, 3, "R3"); run_cmd(3, 1, 7, "R3");
        run_cmd(1, 1, 3, "R3"); run_cmd(3, 1, 3, "R3");
        // R4: duplicate add
        run_cmd(1, 2, 3, "R4"); run_cmd(1, 2, 3, "R4"); run_cmd(1, 2, 5, "R4"); run_cmd(3, 2, 0, "R4");
        // R5: remove in pointer mode
        run_cmd(1, 2, 9, "R5"); run_cmd(2, 2, 0, "R5"); run_cmd(3, 2, 14, "R5");
        // R6 R7 R8: overflow per policy
        run_cmd(1, 3, 3, ""); run_cmd(1, 3, 5, ""); run_cmd(1, 3, 9, ""); run_cmd(1, 3, 12, "");
        run_cmd(1, 3, 13, ""); run_cmd(3, 3, 0, "");
        // R9: remove ignored while overflowed
        run_cmd(1, 1, 4, ""); run_cmd(1, 1, 6, ""); run_cmd(2, 1, 6, "R9"); run_cmd(2, 1, 4, "R9");
        run_cmd(3, 1, 15, "R9");
        // R10: entry holds only the writer
        run_cmd(3, 1, 2, "R10"); run_cmd(1, 1, 8, "R10"); run_cmd(1, 1, 11, "R10"); run_cmd(3, 1, 8, "R10");
        // R12: other blocks untouched
        run_cmd(1, 0, 10, "R12"); run_cmd(1, 0, 11, "R12"); run_cmd(1, 0, 12, "R12");
        run_cmd(3, 2, 1, "R12"); run_cmd(3, 0, 1, "");
        // Random mix
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom_range(0, 9));
            int op = (r < 5) ? 1 : (r < 7) ? 2 : 3;
            run_cmd(op, int'($urandom_range(0, BLOCKS - 1)), int'($urandom_range(0, NODES - 1)), "");
        end
        for (int b = 0; b < BLOCKS; b++) run_cmd(3, b, 0, "");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule